// File: doc/BRIEF.md
# Converter Data-Ready Flag Controller

This block sequences the data register and the active-low data-ready line of an oversampling converter whose decimation filter hands out one word per output-rate period. The filter side signals each finished period with a single-cycle tick and offers the new word beside it. The controller decides whether that word may enter the data register, and it drives the ready line. A host clears the line by reading the register.

After any restart the filter needs three full output periods before its words are valid. The restart sources are reset release, a filter-sync command and leaving standby. The controller counts output-rate ticks to track this settling. The ready line does not simply follow loads. If the host has not yet read a held word, a restart leaves the line low. If a new word replaces an unread one, the line is lifted high for a fixed number of master clocks and then falls again, so the host sees a fresh edge. A standby control stops loading but keeps the held word, which can still be read.

Top module: `drdy_ctrl`

## Requirements
- R1: While `rst_n` is low, `rdy_n` is 1, `data_reg` is 0 and `wr_blocked` is 1. Sync, read, standby and tick inputs have no effect during reset, and the settling count is cleared.
- R2: After `rst_n` rises, the first two `rate_tick` pulses load nothing. The third loads `sample_in` into `data_reg` and drives `rdy_n` low at that same clock edge.
- R3: A `sync_cmd` pulse restarts settling. The next two ticks load nothing. The third tick after the sync loads a word. A tick in the same cycle as `sync_cmd` is not counted.
- R4: If `rdy_n` is 0 when `sync_cmd` arrives, `rdy_n` stays 0 until the next read or load.
- R5: If `rdy_n` is 1 when `sync_cmd` arrives, `rdy_n` stays 1 until the settling period is over and a word is loaded.
- R6: A load while `rdy_n` is 0, with no read in that cycle, updates `data_reg` and holds `rdy_n` at 1 for exactly PULSE_CLKS clocks. `rdy_n` then returns to 0.
- R7: A `rd_stb` pulse sets `rdy_n` to 1 at the next edge and cancels any pulse still running. `rdy_n` stays 1 until the next load.
- R8: A read and a load in the same cycle present the new word in `data_reg` and leave `rdy_n` at 1 until the following load.
- R9: While `stby` is 1, no word is loaded and `data_reg` keeps its value. Entering standby does not change `rdy_n`, and a read during standby still sets `rdy_n` to 1.
- R10: When `stby` falls, settling restarts. A tick in the same cycle as the falling `stby` is not counted, and the third tick after it loads a word.
- R11: Once settled and out of standby, every tick loads `sample_in`. If no pulse is running and no read coincides, a load with `rdy_n` at 1 drives `rdy_n` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_cmd | input | 1 | Single-cycle filter restart command |
| stby | input | 1 | Standby level; 1 stops loading |
| rd_stb | input | 1 | Single-cycle data-register read strobe |
| rate_tick | input | 1 | Single-cycle end-of-output-period tick from the filter |
| sample_in | input | DW | Word offered by the filter with each tick |
| rdy_n | output | 1 | Active-low data-ready line |
| data_reg | output | DW | Data register contents |
| wr_blocked | output | 1 | High while register writes are ignored (reset held) |

## Verification
The bench builds the block with DW at 16, SETTLE_TICKS at 3 and PULSE_CLKS reduced from 500 to 12. With the short pulse, the high pulse can be measured to the exact clock edge. The random phase can then place ticks, reads and syncs inside a running pulse, where pulse expiry, reads and loads of unread words overlap. The three-period settling is left at its real value, so the count boundaries after reset, sync and standby exit are checked as the design actually uses them.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  // Saturating increment of the settling count.
  function automatic int settle_next(input int cnt, input int limit);
    return (cnt >= limit) ? limit : cnt + 1;
  endfunction

  // A tick completes settling when it is the limit-th tick since restart.
  function automatic bit tick_settles(input int cnt, input int limit);
    return (cnt + 1) >= limit;
  endfunction
endpackage

// File: rtl/drdy_settle.sv
module drdy_settle #(
  parameter int SETTLE_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_cmd,
  input  logic stby,
  input  logic rate_tick,
  output logic load_evt,
  output logic restart_evt
);
  import drdy_pkg::*;
  localparam int CW = $clog2(SETTLE_TICKS + 1);

  logic [CW-1:0] scnt;
  logic          stby_q;
  logic          stby_exit;

  assign stby_exit   = stby_q & ~stby;
  assign restart_evt = sync_cmd | stby_exit;
  assign load_evt    = rate_tick & ~stby & ~restart_evt
                       & tick_settles(int'(scnt), SETTLE_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt   <= '0;
      stby_q <= 1'b0;
    end else begin
      stby_q <= stby;
      if (restart_evt)
        scnt <= '0;
      else if (rate_tick && !stby)
        scnt <= CW'(settle_next(int'(scnt), SETTLE_TICKS));
    end
  end

  AST_SCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(scnt) <= SETTLE_TICKS); // R3
  AST_RESTART_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> !load_evt); // R10
endmodule

// File: rtl/drdy_flag.sv
module drdy_flag #(
  parameter int PULSE_CLKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_evt,
  input  logic rd_stb,
  output logic rdy_n,
  output logic pulse_active
);
  localparam int PW = $clog2(PULSE_CLKS + 1);

  logic [PW-1:0] pcnt;

  assign pulse_active = (pcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_n <= 1'b1;
      pcnt  <= '0;
    end else if (rd_stb) begin
      rdy_n <= 1'b1;
      pcnt  <= '0;
    end else if (pulse_active) begin
      pcnt <= pcnt - PW'(1);
      if (pcnt == PW'(1)) rdy_n <= 1'b0;
    end else if (load_evt) begin
      if (!rdy_n) begin
        rdy_n <= 1'b1;
        pcnt  <= PW'(PULSE_CLKS);
      end else begin
        rdy_n <= 1'b0;
      end
    end
  end

  AST_READ_SETS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rdy_n); // R7
  AST_UNREAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !rdy_n && !rd_stb) |=> rdy_n); // R6
  AST_PULSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active |-> rdy_n); // R6
endmodule

// File: rtl/drdy_dreg.sv
module drdy_dreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_evt,
  input  logic [DW-1:0] sample_in,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (load_evt) data_q <= sample_in;
  end
endmodule

// File: rtl/drdy_ctrl.sv
module drdy_ctrl #(
  parameter int DW           = 16,
  parameter int SETTLE_TICKS = 3,
  parameter int PULSE_CLKS   = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_cmd,
  input  logic          stby,
  input  logic          rd_stb,
  input  logic          rate_tick,
  input  logic [DW-1:0] sample_in,
  output logic          rdy_n,
  output logic [DW-1:0] data_reg,
  output logic          wr_blocked
);
  logic load_evt;
  logic restart_evt;
  logic pulse_active;

  assign wr_blocked = ~rst_n;

  drdy_settle #(.SETTLE_TICKS(SETTLE_TICKS)) settle_i (
    .clk(clk), .rst_n(rst_n), .sync_cmd(sync_cmd), .stby(stby),
    .rate_tick(rate_tick), .load_evt(load_evt), .restart_evt(restart_evt)
  );

  drdy_flag #(.PULSE_CLKS(PULSE_CLKS)) flag_i (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .rd_stb(rd_stb),
    .rdy_n(rdy_n), .pulse_active(pulse_active)
  );

  drdy_dreg #(.DW(DW)) dreg_i (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt),
    .sample_in(sample_in), .data_q(data_reg)
  );

  AST_SYNC_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_cmd && !rdy_n && !rd_stb) |=> !rdy_n); // R4
  AST_SYNC_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_cmd && rdy_n && !pulse_active) |=> rdy_n); // R5
  AST_STBY_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> $stable(data_reg)); // R9
endmodule

// File: tb/drdy_ctrl_tb.sv
module drdy_ctrl_tb_top;
  localparam int DW = 16;
  localparam int ST = 3;
  localparam int PC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_cmd = 1'b0, stby = 1'b0, rd_stb = 1'b0, rate_tick = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic rdy_n, wr_blocked;
  logic [DW-1:0] data_reg;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  drdy_ctrl #(.DW(DW), .SETTLE_TICKS(ST), .PULSE_CLKS(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_cmd(sync_cmd), .stby(stby),
    .rd_stb(rd_stb), .rate_tick(rate_tick), .sample_in(sample_in),
    .rdy_n(rdy_n), .data_reg(data_reg), .wr_blocked(wr_blocked)
  );

  // Reference model: ticks since last restart, and the cycle a pulse ends.
  int m_since, m_end;
  bit m_rdy, m_stby_prev;
  logic [DW-1:0] m_data;

  function automatic bit m_loads(input int since, input bit restart);
    return rate_tick && !stby && !restart && (since + 1 >= ST);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_since = 0; m_end = 0; m_rdy = 1; m_stby_prev = 0; m_data = '0;
    end else begin
      bit rs, ld;
      rs = sync_cmd || (m_stby_prev && !stby);
      ld = m_loads(m_since, rs);
      if (rs) m_since = 0;
      else if (rate_tick && !stby) m_since++;
      m_stby_prev = stby;
      if (ld) m_data = sample_in;
      if (rd_stb) begin m_rdy = 1; m_end = 0; end
      else if (m_end != 0) begin
        if (cyc == m_end) begin m_rdy = 0; m_end = 0; end
      end else if (ld) begin
        if (!m_rdy) begin m_rdy = 1; m_end = cyc + PC; end
        else m_rdy = 0;
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic drive(input bit t, input bit s, input bit r);
    rate_tick = t; sync_cmd = s; rd_stb = r;
    @(negedge clk);
    rate_tick = 0; sync_cmd = 0; rd_stb = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7));
    @(negedge clk);
    // R1: reset holds everything
    sample_in = 16'hBEEF;
    drive(1, 1, 1); drive(1, 0, 0); stby = 1; drive(1, 0, 1); stby = 0;
    chk("R1 rdy_n in reset", rdy_n, 1);
    chk("R1 data in reset", data_reg, 0);
    chk("R1 wr_blocked", wr_blocked, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 wr_blocked released", wr_blocked, 0);
    // R2: third tick after reset loads
    sample_in = 16'hA5A5;
    drive(1, 0, 0); drive(1, 0, 0);
    chk("R2 no load after two ticks", rdy_n, 1);
    chk("R2 data after two ticks", data_reg, 0);
    drive(1, 0, 0);
    chk("R2 rdy_n after third tick", rdy_n, 0);
    chk("R2 data after third tick", data_reg, 16'hA5A5);
    // R7: read
    drive(0, 0, 1);
    chk("R7 read sets high", rdy_n, 1);
    drive(0, 0, 0);
    chk("R7 stays high", rdy_n, 1);
    // R11: settled load after read
    sample_in = 16'h1234;
    drive(1, 0, 0);
    chk("R11 load drives low", rdy_n, 0);
    chk("R11 data", data_reg, 16'h1234);
    // R6: unread overwrite pulse
    sample_in = 16'h5678;
    drive(1, 0, 0);
    chk("R6 pulse starts", rdy_n, 1);
    chk("R6 data", data_reg, 16'h5678);
    repeat (PC - 1) drive(0, 0, 0);
    chk("R6 still high at PC-1", rdy_n, 1);
    drive(0, 0, 0);
    chk("R6 low after PC", rdy_n, 0);
    // R4 / R3: sync with unread word
    drive(0, 1, 0);
    chk("R4 sync keeps low", rdy_n, 0);
    sample_in = 16'h9ABC;
    drive(1, 0, 0); drive(1, 0, 0);
    chk("R4 still low", rdy_n, 0);
    chk("R3 no load before settle", data_reg, 16'h5678);
    drive(1, 0, 0);
    chk("R3 third tick loads", data_reg, 16'h9ABC);
    chk("R3 unread overwrite pulses", rdy_n, 1);
    repeat (PC) drive(0, 0, 0);
    chk("R6 pulse ends", rdy_n, 0);
    // R5: sync with line high
    drive(0, 0, 1);
    drive(1, 1, 0);
    chk("R5 sync keeps high", rdy_n, 1);
    drive(1, 0, 0); drive(1, 0, 0);
    chk("R5 high during settle", rdy_n, 1);
    sample_in = 16'h0F0F;
    drive(1, 0, 0);
    chk("R5 low after settle", rdy_n, 0);
    chk("R5 data", data_reg, 16'h0F0F);
    // R8: read with load
    sample_in = 16'h1111;
    drive(1, 0, 1);
    chk("R8 data", data_reg, 16'h1111);
    chk("R8 rdy_n high", rdy_n, 1);
    repeat (PC + 2) drive(0, 0, 0);
    chk("R8 stays high", rdy_n, 1);
    sample_in = 16'h2222;
    drive(1, 0, 0);
    chk("R8 next load low", rdy_n, 0);
    // R9: standby
    stby = 1;
    drive(0, 0, 0);
    chk("R9 entry keeps rdy_n", rdy_n, 0);
    sample_in = 16'h3333;
    drive(1, 0, 0);
    chk("R9 no load", data_reg, 16'h2222);
    drive(0, 0, 1);
    chk("R9 read in standby", rdy_n, 1);
    drive(1, 0, 0); drive(1, 0, 0);
    chk("R9 held data", data_reg, 16'h2222);
    // R10: exit
    stby = 0;
    sample_in = 16'h4444;
    drive(1, 0, 0);
    drive(1, 0, 0); drive(1, 0, 0);
    chk("R10 no load before settle", data_reg, 16'h2222);
    drive(1, 0, 0);
    chk("R10 load after exit", data_reg, 16'h4444);
    chk("R10 rdy_n", rdy_n, 0);
    // R11: random mix against the model
    for (int i = 0; i < 20000; i++) begin
      chk("R11 model rdy_n", rdy_n, m_rdy);
      chk("R11 model data", data_reg, m_data);
      rate_tick = ($urandom_range(0, 9) == 0);
      sync_cmd  = ($urandom_range(0, 149) == 0);
      rd_stb    = ($urandom_range(0, 24) == 0);
      if ($urandom_range(0, 299) == 0) stby = ~stby;
      sample_in = DW'($urandom);
      @(negedge clk);
    end
    rate_tick = 0; sync_cmd = 0; rd_stb = 0;
    finish_run();
  end
endmodule